// File: doc/BRIEF.md
# Nibble-Wide Ethernet Frame Transmitter with Error-by-Corrupted-Checksum

This block is the transmit side of a MAC-to-PHY media independent link. A MAC-side source offers payload bytes through a valid/ready handshake. `in_last` marks the final byte, and `in_abort` reports an unrecoverable problem with the frame. The block turns each frame into a stream of 4-bit nibbles on `txd`, with `tx_en` high for every nibble that belongs to the frame. Everything runs on `tx_clk`, the clock that the PHY supplies. The logic counts clock cycles and has no notion of time, so it works unchanged at 25 MHz or at 2.5 MHz.

A frame on the line has these parts, in order:
- a preamble and a start-of-frame delimiter;
- the payload, zero-padded to 60 bytes;
- a 32-bit CRC frame check sequence;
- an interframe gap of at least 24 idle nibbles, which follows the frame.

The error pin `tx_er` is never used and stays low. An error is reported instead by sending the last byte of the check sequence bit-inverted, so the receiver rejects the frame. Two events cause this: an abort request, or the source running dry before its last byte.

The controller has seven states:
- **IDLE** goes to PREAM when `in_valid` is high.
- **PREAM** sends 14 nibbles of 0x5, then goes to SFD.
- **SFD** sends 0x5 and then 0xD, and fetches the first byte. It goes to DATA if that byte is there, and to PAD on an under-run.
- **DATA** sends the low nibble and then the high nibble of each byte. After the last byte, or on an under-run, it goes to PAD if fewer than 60 bytes have been sent and to FCS otherwise.
- **PAD** sends zero nibbles until 60 bytes have gone out, then goes to FCS.
- **FCS** sends 8 nibbles, then goes to GAP.
- **GAP** holds the line idle for 24 nibbles. It then goes to PREAM if a byte is waiting, and to IDLE otherwise.

Top module: `mii_frame_tx`

## Requirements
- R1: `tx_er` is 0 in every cycle.
- R2: While reset is held and after reset is released, `tx_en`, `txd` and `in_ready` are 0 until a frame starts.
- R3: A frame opens with 15 nibbles of 0x5 followed by one nibble 0xD, and `tx_en` stays high without a break from the first of these nibbles to the last nibble of the check sequence. The frame then has 16 + 2·N + 8 nibbles, where N is the padded byte count.
- R4: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. Payload bytes go out in the order they were taken, the low nibble (bits 3:0) before the high nibble (bits 7:4).
- R5: A payload shorter than 60 bytes is followed by zero bytes up to a total of 60. A payload of 60 bytes or more gets no padding.
- R6: The check sequence is the reflected CRC-32 (polynomial 0x04C11DB7, start value 0xFFFFFFFF, result complemented), computed over all payload and pad bytes. It is sent from bit 0 upward, four bits per nibble, so the least significant byte goes first.
- R7: An `in_abort` pulse seen during PREAM, SFD, DATA or PAD inverts all 8 bits of the last check-sequence byte (its last two nibbles). The frame keeps its full length.
- R8: An under-run happens when `in_ready` is high and `in_valid` is low before the byte marked `in_last` has been taken. The frame then ends after the bytes already taken, is padded as in R5, and carries an inverted last check byte.
- R9: `in_abort` has no effect while the block is sending the check sequence, in the gap, or in IDLE: the next check sequence is correct.
- R10: `tx_en` stays low for at least 24 cycles between frames. The gap is exactly 24 cycles when the next frame's first byte is already waiting at the end of the gap.
- R11: `txd` is 0 in every cycle in which `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | PHY-supplied transmit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Payload byte offered by the source |
| in_valid | input | 1 | `in_data` holds a byte; also requests the start of a frame when the block is idle |
| in_last | input | 1 | The offered byte is the final byte of the payload |
| in_abort | input | 1 | Unrecoverable error in the current frame |
| in_ready | output | 1 | The block takes the offered byte at this rising edge |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | High for every nibble of the frame |
| tx_er | output | 1 | Transmit error flag, held at 0 |

## Verification
Assertions check these properties in every cycle:
- `txd` is quiet while `tx_en` is low;
- each frame opens with a 0x5 nibble;
- `in_ready` is high only inside a frame;
- the error flag, once set, holds until the frame ends;
- `tx_en` drops right after the eighth check nibble;
- the line stays idle for at least 24 cycles between frames.

Only the bench scenarios can show that the frame content is right: the order of payload nibbles, the zero padding at the 59, 60 and 61 byte boundaries, and the CRC value. They also show that the inversion falls on the last check byte only, for an abort and for an under-run. Finally, they show that an abort during the check sequence or in idle is ignored, and that a waiting frame follows after exactly 24 idle cycles.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAM,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // One 4-bit step of the reflected CRC-32; bit 0 of the nibble is consumed first.
    function automatic logic [31:0] crc_step_nib(input logic [31:0] c_in, input logic [3:0] nib);
        logic [31:0] c;
        c = c_in ^ {28'd0, nib};
        for (int k = 0; k < 4; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_tx_crc.sv
`timescale 1ns/1ps
module mii_tx_crc
    import mii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [3:0]  nib,
    output logic [31:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (restart) begin
            crc <= CRC_SEED;
        end else if (step) begin
            crc <= crc_step_nib(crc, nib);
        end
    end

endmodule

// File: rtl/mii_tx_fcs_sel.sv
`timescale 1ns/1ps
module mii_tx_fcs_sel #(
    parameter int FCS_NIBS = 8
) (
    input  logic [31:0]                   crc,
    input  logic [$clog2(FCS_NIBS)-1:0]   idx,
    input  logic                          corrupt,
    output logic [3:0]                    nib
);

    localparam int IW = $clog2(FCS_NIBS);
    localparam int LAST_BYTE_FIRST_NIB = FCS_NIBS - 2;

    logic [31:0] fcs_word;
    logic [3:0]  picked;
    logic        in_last_byte;

    assign fcs_word     = ~crc;
    assign picked       = fcs_word[{idx, 2'b00} +: 4];
    assign in_last_byte = (idx >= IW'(LAST_BYTE_FIRST_NIB));
    assign nib          = picked ^ {4{corrupt & in_last_byte}};

endmodule

// File: rtl/mii_frame_tx.sv
`timescale 1ns/1ps
module mii_frame_tx
    import mii_tx_pkg::*;
#(
    parameter int PRE_BYTES = 7,
    parameter int MIN_BYTES = 60,
    parameter int GAP_NIBS  = 24
) (
    input  logic       tx_clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       in_abort,
    output logic       in_ready,
    output logic [3:0] txd,
    output logic       tx_en,
    output logic       tx_er
);

    localparam int FCS_NIBS = 8;
    localparam int PRE_NIBS = 2 * PRE_BYTES;
    localparam int TOP_A    = (PRE_NIBS > GAP_NIBS) ? PRE_NIBS : GAP_NIBS;
    localparam int CNT_TOP  = (TOP_A > FCS_NIBS) ? TOP_A : FCS_NIBS;
    localparam int CW       = $clog2(CNT_TOP + 1);
    localparam int BW       = $clog2(MIN_BYTES + 1);
    localparam int FW       = $clog2(FCS_NIBS);

    tx_state_t     state;
    logic [CW-1:0] cnt;
    logic          ph;
    logic [7:0]    cur_byte;
    logic          last_q;
    logic          err_q;
    logic [BW-1:0] bcnt;
    logic [BW:0]   bcnt_inc;

    logic [3:0]    data_nib;
    logic [31:0]   crc;
    logic [3:0]    fcs_nib;
    logic          crc_restart;
    logic          crc_step;

    assign bcnt_inc = {1'b0, bcnt} + 1'b1;
    assign data_nib = ph ? cur_byte[7:4] : cur_byte[3:0];
    assign tx_er    = 1'b0;

    // State register and frame datapath
    always_ff @(posedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            ph       <= 1'b0;
            cur_byte <= '0;
            last_q   <= 1'b0;
            err_q    <= 1'b0;
            bcnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_PREAM;
                        cnt   <= '0;
                        err_q <= 1'b0;
                    end
                end
                ST_PREAM: begin
                    err_q <= err_q | in_abort;
                    if (cnt == CW'(PRE_NIBS - 1)) begin
                        state <= ST_SFD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SFD: begin
                    err_q <= err_q | in_abort;
                    if (cnt == '0) begin
                        cnt <= CW'(1);
                    end else begin
                        bcnt <= '0;
                        ph   <= 1'b0;
                        if (in_valid) begin
                            cur_byte <= in_data;
                            last_q   <= in_last;
                            state    <= ST_DATA;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_PAD;
                        end
                    end
                end
                ST_DATA: begin
                    err_q <= err_q | in_abort;
                    ph    <= ~ph;
                    if (ph) begin
                        bcnt <= (bcnt_inc > (BW+1)'(MIN_BYTES)) ? BW'(MIN_BYTES) : bcnt_inc[BW-1:0];
                        if (!last_q && in_valid) begin
                            cur_byte <= in_data;
                            last_q   <= in_last;
                        end else begin
                            if (!last_q) begin
                                err_q <= 1'b1;
                            end
                            cnt   <= '0;
                            state <= (bcnt_inc < (BW+1)'(MIN_BYTES)) ? ST_PAD : ST_FCS;
                        end
                    end
                end
                ST_PAD: begin
                    err_q <= err_q | in_abort;
                    ph    <= ~ph;
                    if (ph) begin
                        bcnt <= bcnt_inc[BW-1:0];
                        if (bcnt_inc >= (BW+1)'(MIN_BYTES)) begin
                            cnt   <= '0;
                            state <= ST_FCS;
                        end
                    end
                end
                ST_FCS: begin
                    if (cnt == CW'(FCS_NIBS - 1)) begin
                        cnt   <= '0;
                        state <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == CW'(GAP_NIBS - 1)) begin
                        cnt <= '0;
                        if (in_valid) begin
                            state <= ST_PREAM;
                            err_q <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign crc_restart = (state == ST_SFD);
    assign crc_step    = (state == ST_DATA) || (state == ST_PAD);

    mii_tx_crc u_crc (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .step    (crc_step),
        .nib     ((state == ST_PAD) ? 4'h0 : data_nib),
        .crc     (crc)
    );

    mii_tx_fcs_sel #(.FCS_NIBS(FCS_NIBS)) u_fcs (
        .crc     (crc),
        .idx     (cnt[FW-1:0]),
        .corrupt (err_q),
        .nib     (fcs_nib)
    );

    // Output decode
    always_comb begin
        txd      = 4'h0;
        tx_en    = 1'b0;
        in_ready = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                txd   = 4'h0;
                tx_en = 1'b0;
            end
            ST_PREAM: begin
                txd   = 4'h5;
                tx_en = 1'b1;
            end
            ST_SFD: begin
                txd      = (cnt == '0) ? 4'h5 : 4'hD;
                tx_en    = 1'b1;
                in_ready = (cnt != '0);
            end
            ST_DATA: begin
                txd      = data_nib;
                tx_en    = 1'b1;
                in_ready = ph & ~last_q;
            end
            ST_PAD: begin
                txd   = 4'h0;
                tx_en = 1'b1;
            end
            ST_FCS: begin
                txd   = fcs_nib;
                tx_en = 1'b1;
            end
        endcase
    end

    // Checks on the running design
    localparam int GW = $clog2(GAP_NIBS + 1);
    logic [GW-1:0] low_run;
    logic          seen_frame;

    always_ff @(posedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run    <= '0;
            seen_frame <= 1'b0;
        end else if (tx_en) begin
            low_run    <= '0;
            seen_frame <= 1'b1;
        end else if (low_run < GW'(GAP_NIBS)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r11_quiet_line: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0));

    a_r3_opens_with_preamble: assert property (@(posedge tx_clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5));

    a_r4_ready_inside_frame: assert property (@(posedge tx_clk) disable iff (!rst_n)
        in_ready |-> tx_en);

    a_r7_error_sticky: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (err_q && (state inside {ST_PREAM, ST_SFD, ST_DATA, ST_PAD, ST_FCS})) |=> err_q);

    a_r6_fcs_closes_frame: assert property (@(posedge tx_clk) disable iff (!rst_n)
        ((state == ST_FCS) && (cnt == CW'(FCS_NIBS - 1))) |=> !tx_en);

    a_r10_min_gap: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_en && seen_frame && (low_run != '0)) |-> (low_run >= GW'(GAP_NIBS)));

endmodule

// File: tb/mii_frame_tx_test.sv
`timescale 1ns/1ps
module mii_frame_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_abort = 1'b0;
    logic       in_ready;
    logic [3:0] txd;
    logic       tx_en;
    logic       tx_er;

    always #2.5 clk = ~clk;

    mii_frame_tx uut (
        .tx_clk   (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_abort (in_abort),
        .in_ready (in_ready),
        .txd      (txd),
        .tx_en    (tx_en),
        .tx_er    (tx_er)
    );

    int n_checks = 0;
    int n_err    = 0;

    // Line monitor
    logic [3:0] nib_buf [0:511];
    int nib_cnt   = 0;
    int last_gap  = 0;
    int low_run   = 1000;
    int quiet_bad = 0;
    int er_bad    = 0;
    bit prev_en   = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_er !== 1'b0) er_bad++;
            if (tx_en) begin
                if (!prev_en) begin
                    nib_cnt  = 0;
                    last_gap = low_run;
                end
                if (nib_cnt < 512) nib_buf[nib_cnt] = txd;
                nib_cnt++;
                low_run = 0;
            end else begin
                low_run++;
                if (txd !== 4'h0) quiet_bad++;
            end
            prev_en = tx_en;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 37 + (i >> 3)) & 255);
    endfunction

    task automatic send_frame(input int len, input int seed, input int abort_idx, input int under_idx);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            if (i == under_idx) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                in_abort = 1'b0;
                return;
            end
            in_data  = pat(seed, i);
            in_last  = (i == len - 1);
            in_valid = 1'b1;
            in_abort = (i == abort_idx);
            forever begin
                if (in_ready) break;
                @(negedge clk);
            end
            @(negedge clk);
            in_abort = 1'b0;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_end();
        while (tx_en !== 1'b1) @(negedge clk);
        while (tx_en === 1'b1) @(negedge clk);
    endtask

    task automatic check_frame(input int nb, input int seed, input bit corrupt,
                               input string fcs_req, input string tag);
        logic [7:0]  b [0:255];
        logic [31:0] c;
        logic [31:0] fcs_exp;
        logic [31:0] fcs_act;
        int n;
        int bad;
        n = (nb < 60) ? 60 : nb;
        for (int i = 0; i < n; i++) b[i] = (i < nb) ? pat(seed, i) : 8'h00;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        fcs_exp = ~c;
        if (corrupt) fcs_exp[31:24] = ~fcs_exp[31:24];

        check(nib_cnt == 16 + 2 * n + 8, "R3", {tag, " frame nibble count"}, nib_cnt, 16 + 2 * n + 8);
        bad = 0;
        for (int k = 0; k < 15; k++) if (nib_buf[k] !== 4'h5) bad++;
        if (nib_buf[15] !== 4'hD) bad++;
        check(bad == 0, "R3", {tag, " preamble/SFD bad nibbles"}, bad, 0);
        bad = 0;
        for (int i = 0; i < nb; i++) begin
            if (nib_buf[16 + 2 * i]     !== b[i][3:0]) bad++;
            if (nib_buf[16 + 2 * i + 1] !== b[i][7:4]) bad++;
        end
        check(bad == 0, "R4", {tag, " payload bad nibbles"}, bad, 0);
        bad = 0;
        for (int i = 2 * nb; i < 2 * n; i++) if (nib_buf[16 + i] !== 4'h0) bad++;
        check(bad == 0, "R5", {tag, " pad bad nibbles"}, bad, 0);
        for (int k = 0; k < 8; k++) fcs_act[4 * k +: 4] = nib_buf[16 + 2 * n + k];
        check(fcs_act == fcs_exp, fcs_req, {tag, " FCS"}, fcs_act, fcs_exp);
    endtask

    // len, abort index, under-run index, expected data bytes, expected corruption
    localparam int NV = 8;
    localparam logic [32:0] VEC [0:NV-1] = '{
        {8'd1,   8'hFF, 8'hFF, 8'd1,   1'b0},
        {8'd60,  8'hFF, 8'hFF, 8'd60,  1'b0},
        {8'd61,  8'hFF, 8'hFF, 8'd61,  1'b0},
        {8'd59,  8'hFF, 8'hFF, 8'd59,  1'b0},
        {8'd20,  8'd5,  8'hFF, 8'd20,  1'b1},
        {8'd70,  8'hFF, 8'd30, 8'd30,  1'b1},
        {8'd100, 8'd0,  8'hFF, 8'd100, 1'b1},
        {8'd45,  8'd44, 8'hFF, 8'd45,  1'b1}
    };

    initial begin
        #(200000 * 5);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        check(tx_en === 1'b0, "R2", "tx_en in reset", tx_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_en === 1'b0, "R2", "tx_en after reset", tx_en, 0);
        check(txd === 4'h0, "R2", "txd after reset", txd, 0);
        check(in_ready === 1'b0, "R2", "in_ready after reset", in_ready, 0);
        check(tx_er === 1'b0, "R1", "tx_er after reset", tx_er, 0);

        // Table-driven frames: R3..R8, R10
        for (int v = 0; v < NV; v++) begin
            int len, ab, un, nb;
            bit bad_exp;
            len     = int'(VEC[v][32:25]);
            ab      = (VEC[v][24:17] == 8'hFF) ? -1 : int'(VEC[v][24:17]);
            un      = (VEC[v][16:9]  == 8'hFF) ? -1 : int'(VEC[v][16:9]);
            nb      = int'(VEC[v][8:1]);
            bad_exp = VEC[v][0];
            send_frame(len, v * 17 + 3, ab, un);
            wait_end();
            check_frame(nb, v * 17 + 3, bad_exp, bad_exp ? ((un >= 0) ? "R8" : "R7") : "R6",
                        $sformatf("vec%0d", v));
            check(last_gap >= 24, "R10", $sformatf("vec%0d gap", v), last_gap, 24);
        end

        // R9: abort while idle is ignored
        repeat (30) @(negedge clk);
        in_abort = 1'b1;
        repeat (3) @(negedge clk);
        in_abort = 1'b0;
        send_frame(10, 91, -1, -1);
        wait_end();
        check_frame(10, 91, 1'b0, "R9", "abort_idle");

        // R9: abort during the check sequence is ignored
        repeat (30) @(negedge clk);
        send_frame(64, 55, -1, -1);
        repeat (3) @(negedge clk);
        in_abort = 1'b1;
        repeat (2) @(negedge clk);
        in_abort = 1'b0;
        wait_end();
        check_frame(64, 55, 1'b0, "R9", "abort_fcs");

        // R10: back-to-back frames, exact gap
        repeat (30) @(negedge clk);
        send_frame(12, 7, -1, -1);
        fork
            send_frame(65, 8, -1, -1);
            begin
                wait_end();
                check_frame(12, 7, 1'b0, "R6", "b2b_first");
            end
        join
        wait_end();
        check_frame(65, 8, 1'b0, "R6", "b2b_second");
        check(last_gap == 24, "R10", "back-to-back gap", last_gap, 24);

        // R8: under-run right after the first byte
        repeat (30) @(negedge clk);
        send_frame(40, 33, -1, 1);
        wait_end();
        check_frame(1, 33, 1'b1, "R8", "underrun_1");

        repeat (5) @(negedge clk);
        check(quiet_bad == 0, "R11", "txd nonzero while idle", quiet_bad, 0);
        check(er_bad == 0, "R1", "tx_er high cycles", er_bad, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule